// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block decides, for a five-stage in-order scalar integer pipeline, where each of the two ALU source operands in the execute stage comes from. It compares each execute-stage source register number against the destination of the instruction now in the memory stage and the one now in writeback, and drives a two-bit multiplexer select per operand. A dependency that only looks like one, because the older instruction does not write a register or names register 0, causes no action.

Two further bypass paths sit inside the block. The first is a register file whose read ports see a value written by writeback in the same cycle. The second is a store-data path: when a load in writeback feeds the data register of the store right behind it in the memory stage, the loaded word replaces the store's data, so a memory copy runs without a bubble. A load in the memory stage whose result the execute stage needs cannot be served by forwarding. The block flags that operand and never steers it onto the memory-stage path. Stalling on that flag is left to other logic.

The register file is the only state. It is cleared by an active-low reset.

Top module: `fwd_unit_top`

## Requirements
- R1: When the memory-stage instruction writes a non-zero register and is not a load, an execute operand reading that register gets select 2'b10.
- R2: When the writeback-stage instruction writes a non-zero register that an execute operand reads, and the memory stage does not supply that operand, the operand gets select 2'b01.
- R3: An operand whose register is not written by the memory or writeback instruction gets select 2'b00, the register-file path. This includes the case where an older instruction names the register but has its write enable low.
- R4: When the memory and writeback instructions both write the operand's register, the memory-stage result wins and the select is 2'b10.
- R5: Register 0 is never a forwarding source on any path. A read of register 0 returns zero, even in the cycle in which writeback targets it.
- R6: When a load in the memory stage writes an execute operand's register, that operand's bit in the uncovered-hazard output is set (bit 0 for operand A, bit 1 for operand B). The select is then never 2'b10; it falls back to 2'b01 or 2'b00 as R2 and R3 decide.
- R7: A decode-stage read of the register that writeback writes in the same cycle returns the new value. After the clock edge the register holds that value.
- R8: When a load in writeback writes a non-zero register that a store in the memory stage uses as its data source, the store-forward flag is 1 and the store data output is the writeback data. In every other case the flag is 0 and the store data passes through unchanged.
- R9: After reset every register reads zero.
- R10: The two execute operands are resolved independently: they may take the same path or different paths in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the register file |
| id_rs1_i | input | 5 | Decode-stage first read register |
| id_rs2_i | input | 5 | Decode-stage second read register |
| id_rd1_o | output | 32 | Decode-stage first read data, with write-through |
| id_rd2_o | output | 32 | Decode-stage second read data, with write-through |
| ex_rs1_i | input | 5 | Execute-stage operand A source register |
| ex_rs2_i | input | 5 | Execute-stage operand B source register |
| mem_rd_i | input | 5 | Memory-stage destination register |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| mem_is_load_i | input | 1 | Memory-stage instruction is a load |
| mem_is_store_i | input | 1 | Memory-stage instruction is a store |
| mem_st_src_i | input | 5 | Register that supplies the memory-stage store's data |
| mem_st_data_i | input | 32 | Store data carried down the pipeline |
| wb_rd_i | input | 5 | Writeback destination register |
| wb_we_i | input | 1 | Writeback writes a register |
| wb_is_load_i | input | 1 | Writeback instruction is a load |
| wb_data_i | input | 32 | Writeback value |
| fwd_a_o | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 writeback |
| fwd_b_o | output | 2 | Operand B select, same encoding |
| ld_use_o | output | 2 | Uncovered load dependency, bit 0 operand A, bit 1 operand B |
| st_fwd_o | output | 1 | Store data is taken from the writeback load |
| st_data_o | output | 32 | Store data after the memory-to-memory bypass |

## Verification
The bench targets overlapping matches where both older stages write the operand's register. A design with the priority reversed would hand the older writeback value to the ALU. It drives matches whose write enable is low and matches on register 0; a design that ignored these would forward stale or garbage results. It places a load in the memory stage. A design that got this wrong would forward the load's address as data and hide the hazard, where it should raise the uncovered flag. It also exercises same-cycle write and read of one register, where a plain register file returns the old value. Finally it sends store-after-load pairs that differ only in the register, the load flag or register 0. A loose comparator there would corrupt the data of an unrelated store.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;

endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] mem_rd_i,
    input  logic          mem_we_i,
    input  logic          mem_is_load_i,
    input  logic [AW-1:0] wb_rd_i,
    input  logic          wb_we_i,
    output fwd_sel_e      sel_o,
    output logic          ld_use_o
);

    logic src_live;
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        src_live = (src_i != '0);
        mem_hit  = src_live && mem_we_i && (mem_rd_i == src_i);
        wb_hit   = src_live && wb_we_i  && (wb_rd_i  == src_i);
    end

    // The memory stage takes priority, but a load there carries an address, not data.
    always_comb begin
        ld_use_o = mem_hit && mem_is_load_i;
        if (mem_hit && !mem_is_load_i) begin
            sel_o = SEL_MEM;
        end else if (wb_hit) begin
            sel_o = SEL_WB;
        end else begin
            sel_o = SEL_RF;
        end
    end

    assert_sel_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o inside {SEL_RF, SEL_WB, SEL_MEM});

    assert_zero_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == '0) |-> (sel_o == SEL_RF && !ld_use_o));

    assert_mem_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i != '0 && mem_we_i && !mem_is_load_i && mem_rd_i == src_i)
            |-> (sel_o == SEL_MEM));

    assert_load_not_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_use_o |-> (sel_o != SEL_MEM));

endmodule

// File: rtl/fwd_regfile.sv
module fwd_regfile #(
    parameter int NREGS = 32,
    parameter int XLEN  = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   wr_addr_i,
    input  logic            wr_en_i,
    input  logic [XLEN-1:0] wr_data_i,
    input  logic [AW-1:0]   rd_addr1_i,
    input  logic [AW-1:0]   rd_addr2_i,
    output logic [XLEN-1:0] rd_data1_o,
    output logic [XLEN-1:0] rd_data2_o
);

    logic [XLEN-1:0] regs_q [NREGS];
    logic            wr_live;

    assign wr_live = wr_en_i && (wr_addr_i != '0);

    // Register 0 is never stored; its entry stays zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= '0;
            end
        end else if (wr_live) begin
            regs_q[wr_addr_i] <= wr_data_i;
        end
    end

    function automatic logic [XLEN-1:0] read_port(input logic [AW-1:0] addr);
        if (addr == '0) begin
            return '0;
        end else if (wr_live && wr_addr_i == addr) begin
            return wr_data_i;
        end else begin
            return regs_q[addr];
        end
    endfunction

    always_comb begin
        rd_data1_o = read_port(rd_addr1_i);
        rd_data2_o = read_port(rd_addr2_i);
    end

    assert_zero_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr1_i == '0) |-> (rd_data1_o == '0));

    assert_write_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i != '0)
            |=> (rd_addr1_i != $past(wr_addr_i)
                 || (wr_en_i && wr_addr_i == rd_addr1_i)
                 || rd_data1_o == $past(wr_data_i)));

endmodule

// File: rtl/fwd_store_bypass.sv
module fwd_store_bypass #(
    parameter int AW   = 5,
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mem_is_store_i,
    input  logic [AW-1:0]   mem_st_src_i,
    input  logic [XLEN-1:0] mem_st_data_i,
    input  logic [AW-1:0]   wb_rd_i,
    input  logic            wb_we_i,
    input  logic            wb_is_load_i,
    input  logic [XLEN-1:0] wb_data_i,
    output logic            st_fwd_o,
    output logic [XLEN-1:0] st_data_o
);

    always_comb begin
        st_fwd_o = mem_is_store_i && wb_is_load_i && wb_we_i
                   && (wb_rd_i != '0) && (wb_rd_i == mem_st_src_i);
        st_data_o = st_fwd_o ? wb_data_i : mem_st_data_i;
    end

    assert_store_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_is_store_i |-> (st_data_o == mem_st_data_i && !st_fwd_o));

    assert_store_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_st_src_i == '0) |-> !st_fwd_o);

endmodule

// File: rtl/fwd_unit_top.sv
module fwd_unit_top
    import fwd_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int XLEN  = 32,
    localparam int AW   = $clog2(NREGS),
    localparam int NOPS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   id_rs1_i,
    input  logic [AW-1:0]   id_rs2_i,
    output logic [XLEN-1:0] id_rd1_o,
    output logic [XLEN-1:0] id_rd2_o,
    input  logic [AW-1:0]   ex_rs1_i,
    input  logic [AW-1:0]   ex_rs2_i,
    input  logic [AW-1:0]   mem_rd_i,
    input  logic            mem_we_i,
    input  logic            mem_is_load_i,
    input  logic            mem_is_store_i,
    input  logic [AW-1:0]   mem_st_src_i,
    input  logic [XLEN-1:0] mem_st_data_i,
    input  logic [AW-1:0]   wb_rd_i,
    input  logic            wb_we_i,
    input  logic            wb_is_load_i,
    input  logic [XLEN-1:0] wb_data_i,
    output logic [1:0]      fwd_a_o,
    output logic [1:0]      fwd_b_o,
    output logic [NOPS-1:0] ld_use_o,
    output logic            st_fwd_o,
    output logic [XLEN-1:0] st_data_o
);

    logic [AW-1:0] op_src [NOPS];
    fwd_sel_e      op_sel [NOPS];

    assign op_src[0] = ex_rs1_i;
    assign op_src[1] = ex_rs2_i;

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        fwd_operand_sel #(.AW(AW)) i_sel (
            .clk           (clk),
            .rst_n         (rst_n),
            .src_i         (op_src[g]),
            .mem_rd_i      (mem_rd_i),
            .mem_we_i      (mem_we_i),
            .mem_is_load_i (mem_is_load_i),
            .wb_rd_i       (wb_rd_i),
            .wb_we_i       (wb_we_i),
            .sel_o         (op_sel[g]),
            .ld_use_o      (ld_use_o[g])
        );
    end

    assign fwd_a_o = op_sel[0];
    assign fwd_b_o = op_sel[1];

    fwd_regfile #(.NREGS(NREGS), .XLEN(XLEN)) i_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_addr_i  (wb_rd_i),
        .wr_en_i    (wb_we_i),
        .wr_data_i  (wb_data_i),
        .rd_addr1_i (id_rs1_i),
        .rd_addr2_i (id_rs2_i),
        .rd_data1_o (id_rd1_o),
        .rd_data2_o (id_rd2_o)
    );

    fwd_store_bypass #(.AW(AW), .XLEN(XLEN)) i_st (
        .clk            (clk),
        .rst_n          (rst_n),
        .mem_is_store_i (mem_is_store_i),
        .mem_st_src_i   (mem_st_src_i),
        .mem_st_data_i  (mem_st_data_i),
        .wb_rd_i        (wb_rd_i),
        .wb_we_i        (wb_we_i),
        .wb_is_load_i   (wb_is_load_i),
        .wb_data_i      (wb_data_i),
        .st_fwd_o       (st_fwd_o),
        .st_data_o      (st_data_o)
    );

    assert_ops_independent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs1_i == ex_rs2_i) |-> (fwd_a_o == fwd_b_o && ld_use_o[0] == ld_use_o[1]));

endmodule

// File: tb/test_fwd_unit_top.sv
module test_fwd_unit_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  id_rs1, id_rs2, ex_rs1, ex_rs2, mem_rd, mem_st_src, wb_rd;
    logic        mem_we, mem_is_load, mem_is_store, wb_we, wb_is_load;
    logic [31:0] mem_st_data, wb_data, id_rd1, id_rd2, st_data;
    logic [1:0]  fwd_a, fwd_b, ld_use;
    logic        st_fwd;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fwd_unit_top i_fwd_unit_top (
        .clk(clk), .rst_n(rst_n),
        .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_rd1_o(id_rd1), .id_rd2_o(id_rd2),
        .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2),
        .mem_rd_i(mem_rd), .mem_we_i(mem_we), .mem_is_load_i(mem_is_load),
        .mem_is_store_i(mem_is_store), .mem_st_src_i(mem_st_src), .mem_st_data_i(mem_st_data),
        .wb_rd_i(wb_rd), .wb_we_i(wb_we), .wb_is_load_i(wb_is_load), .wb_data_i(wb_data),
        .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .ld_use_o(ld_use),
        .st_fwd_o(st_fwd), .st_data_o(st_data)
    );

    typedef struct packed {
        logic [4:0] rs1;
        logic [4:0] rs2;
        logic [4:0] mrd;
        logic       mwe;
        logic       mld;
        logic [4:0] wrd;
        logic       wwe;
        logic [1:0] exp_a;
        logic [1:0] exp_b;
        logic [1:0] exp_hz;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{5'd1,  5'd2,  5'd3,  1'b1, 1'b0, 5'd4,  1'b1, 2'b00, 2'b00, 2'b00}, // R3 no match
        '{5'd3,  5'd2,  5'd3,  1'b1, 1'b0, 5'd4,  1'b1, 2'b10, 2'b00, 2'b00}, // R1
        '{5'd1,  5'd4,  5'd3,  1'b1, 1'b0, 5'd4,  1'b1, 2'b00, 2'b01, 2'b00}, // R2
        '{5'd5,  5'd6,  5'd5,  1'b1, 1'b0, 5'd5,  1'b1, 2'b10, 2'b00, 2'b00}, // R4
        '{5'd7,  5'd7,  5'd7,  1'b0, 1'b0, 5'd7,  1'b0, 2'b00, 2'b00, 2'b00}, // R3 we low
        '{5'd0,  5'd0,  5'd0,  1'b1, 1'b0, 5'd0,  1'b1, 2'b00, 2'b00, 2'b00}, // R5
        '{5'd8,  5'd9,  5'd8,  1'b1, 1'b1, 5'd8,  1'b1, 2'b01, 2'b00, 2'b01}, // R6 falls to wb
        '{5'd1,  5'd9,  5'd9,  1'b1, 1'b1, 5'd3,  1'b1, 2'b00, 2'b00, 2'b10}, // R6 falls to rf
        '{5'd10, 5'd10, 5'd10, 1'b1, 1'b0, 5'd2,  1'b1, 2'b10, 2'b10, 2'b00}, // R10 same path
        '{5'd11, 5'd12, 5'd11, 1'b1, 1'b0, 5'd12, 1'b1, 2'b10, 2'b01, 2'b00}  // R10 split
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        id_rs1 = '0; id_rs2 = '0; ex_rs1 = '0; ex_rs2 = '0;
        mem_rd = '0; mem_we = 0; mem_is_load = 0; mem_is_store = 0;
        mem_st_src = '0; mem_st_data = '0;
        wb_rd = '0; wb_we = 0; wb_is_load = 0; wb_data = '0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: registers read zero after reset
        id_rs1 = 5'd1; id_rs2 = 5'd31;
        #1;
        chk("R9 rd1", id_rd1, 32'h0);
        chk("R9 rd2", id_rd2, 32'h0);
        chk("R3 reset sel a", {30'b0, fwd_a}, 32'h0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            idle();
            ex_rs1 = VECS[k].rs1; ex_rs2 = VECS[k].rs2;
            mem_rd = VECS[k].mrd; mem_we = VECS[k].mwe; mem_is_load = VECS[k].mld;
            wb_rd = VECS[k].wrd; wb_we = VECS[k].wwe;
            #1;
            chk($sformatf("vec%0d sel a (R1-R6,R10 table)", k), {30'b0, fwd_a}, {30'b0, VECS[k].exp_a});
            chk($sformatf("vec%0d sel b", k), {30'b0, fwd_b}, {30'b0, VECS[k].exp_b});
            chk($sformatf("vec%0d R6 hazard", k), {30'b0, ld_use}, {30'b0, VECS[k].exp_hz});
        end

        // R7: write-through in the same cycle, held after the edge
        @(negedge clk);
        idle();
        wb_we = 1; wb_rd = 5'd5; wb_data = 32'hA5A5_0F0F; id_rs1 = 5'd5; id_rs2 = 5'd6;
        #1;
        chk("R7 same-cycle read", id_rd1, 32'hA5A5_0F0F);
        chk("R7 other reg untouched", id_rd2, 32'h0);
        @(negedge clk);
        wb_we = 0; wb_data = 32'h0;
        #1;
        chk("R7 held after edge", id_rd1, 32'hA5A5_0F0F);

        // R5: write to register 0 is ignored, during and after
        @(negedge clk);
        wb_we = 1; wb_rd = 5'd0; wb_data = 32'hFFFF_FFFF; id_rs2 = 5'd0;
        #1;
        chk("R5 r0 same cycle", id_rd2, 32'h0);
        @(negedge clk);
        wb_we = 0;
        #1;
        chk("R5 r0 after edge", id_rd2, 32'h0);

        // R8: memory-to-memory store data forward
        @(negedge clk);
        idle();
        wb_is_load = 1; wb_we = 1; wb_rd = 5'd6; wb_data = 32'h0000_1234;
        mem_is_store = 1; mem_st_src = 5'd6; mem_st_data = 32'hDEAD_BEEF;
        #1;
        chk("R8 fwd flag", {31'b0, st_fwd}, 32'h1);
        chk("R8 fwd data", st_data, 32'h0000_1234);
        @(negedge clk);
        mem_st_src = 5'd7;
        #1;
        chk("R8 other reg flag", {31'b0, st_fwd}, 32'h0);
        chk("R8 other reg data", st_data, 32'hDEAD_BEEF);
        @(negedge clk);
        mem_st_src = 5'd6; wb_is_load = 0;
        #1;
        chk("R8 not a load", st_data, 32'hDEAD_BEEF);
        @(negedge clk);
        wb_is_load = 1; mem_is_store = 0;
        #1;
        chk("R8 not a store", {31'b0, st_fwd}, 32'h0);
        @(negedge clk);
        mem_is_store = 1; wb_rd = 5'd0; mem_st_src = 5'd0;
        #1;
        chk("R5 store from r0", st_data, 32'hDEAD_BEEF);

        @(negedge clk);
        idle();
        summary();
    end

endmodule